// File: doc/BRIEF.md
# Serial Host Command Port

This block is the device-side end of a clock-synchronous serial link. An external host controller uses it to send command bytes into the device and to read response bytes back. The host raises an active-high select, clocks bits on a serial clock and sends data on one input line. The block answers on a single output line that can run push-pull or tri-state. A separate active-low busy line tells the host whether it may open a new transaction. All serial inputs are brought into the system clock domain. The system clock runs at least four times faster than the serial clock.

Each transaction opens with a header byte. The header holds a six-bit mode code and a direction flag. The block compares the code with a value programmed on a configuration input. On a match it pulls the output line low to acknowledge. On a mismatch the line stays high and the transaction is refused. After an accepted header, one of two things happens. In write direction, each following byte is handed to the internal side as a one-cycle push. In read direction, each following byte is popped from a show-ahead response queue and shifted out. The commands themselves are not interpreted here.

Top module: `sif_host_slave`

## Requirements
- R1: After reset the port behaves as follows: busy is released (sif_busy_n = 1), sif_sdo = 1, sif_sdo_oe = 1 with cfg_tristate = 0, and no push, pop or end pulse occurs.
- R2: The serial clock idles high. Each bit begins at a falling edge, and sif_sdi is sampled on the rising edge. Bytes travel MSB first, 8 clocks per byte. In the header byte, bits 7..2 hold the mode code, bit 1 is the direction (0 = host writes commands, 1 = host reads data) and bit 0 is ignored.
- R3: The header is accepted when its code equals cfg_mode_code and busy is released. sif_sdo then goes low after the 8th rising edge and stays low through the gap that follows.
- R4: When the code differs, sif_sdo stays high for the rest of the transaction, and no byte is pushed or popped.
- R5: In an accepted write, every further 8 clocks produce one cmd_wr_valid pulse carrying the byte received, and sif_sdo stays low.
- R6: In an accepted read, the first falling edge of each data byte pops one byte (rsp_rd_req). The byte's bits then appear on sif_sdo MSB first, each changing on a falling edge.
- R7: Dropping sif_cs mid-transaction aborts it. A partial byte is discarded and not pushed, and the bit counter restarts, so the next header is decoded from its first bit.
- R8: When sif_cs drops after an accepted write that pushed at least one byte, cmd_end pulses once and sif_busy_n goes low. It stays low until cmd_consumed is seen. A header that arrives while busy is refused as in R4.
- R9: With cfg_tristate = 1, sif_sdo_oe is low while sif_cs is low and high while it is high. With cfg_tristate = 0, sif_sdo_oe is always high.
- R10: A read transaction and a refused transaction leave busy released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sif_cs | input | 1 | Transaction select from host, active high |
| sif_sck | input | 1 | Serial clock from host, idles high |
| sif_sdi | input | 1 | Serial data from host |
| sif_sdo | output | 1 | Serial data / acknowledge to host |
| sif_sdo_oe | output | 1 | Output enable for sif_sdo pad |
| sif_busy_n | output | 1 | Low while earlier commands are still pending |
| cfg_mode_code | input | 6 | Mode code a header must carry |
| cfg_tristate | input | 1 | 1 = release sif_sdo while deselected |
| cmd_wr_valid | output | 1 | One-cycle push of a received command byte |
| cmd_wr_data | output | 8 | Command byte being pushed |
| cmd_end | output | 1 | One-cycle pulse at the end of a write transaction |
| cmd_consumed | input | 1 | Internal side has taken the command bytes |
| rsp_rd_req | output | 1 | One-cycle pop of the response queue |
| rsp_rd_data | input | 8 | Head of the show-ahead response queue |

## Verification
The hardest cases to reach from the ports are those that depend on history rather than on the current header. One is a correct header that is refused because an earlier write is still pending. Another is a fresh header that must decode correctly right after an aborted one that left the bit counter part-way through a byte. Random stimulus reaches the first case by choosing at random whether the bench signals consumption after each write. This leaves busy set for some following transactions and covers refusals of both directions. Directed sequences drop select part-way through a header and part-way through a command byte, then send a complete transaction. They check that it is aligned and acknowledged, and that nothing was pushed from the partial byte.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int CODE_W = 6;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_WRITE,
        ST_READ,
        ST_REJECT
    } sif_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rd;
    } sif_hdr_t;

    // Header bits 7..1: code in the upper six, direction below them.
    function automatic sif_hdr_t hdr_decode(input logic [CODE_W:0] b);
        sif_hdr_t h;
        h.code = b[CODE_W:1];
        h.rd   = b[0];
        return h;
    endfunction

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/sif_edge.sv
module sif_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/sif_rx.sv
module sif_rx
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bit_stb,
    input  logic              bit_in,
    output logic [CNT_W-1:0]  cnt,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_q
);
    logic [BYTE_W-2:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (bit_stb) begin
            sh  <= {sh[BYTE_W-3:0], bit_in};
            cnt <= cnt + 1'b1;
        end
    end

    assign byte_stb = bit_stb && (cnt == CNT_W'(BYTE_W-1));
    assign byte_q   = {sh, bit_in};

    // R7: deselect restarts bit alignment
    a_r7_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));
endmodule

// File: rtl/sif_tx.sv
module sif_tx
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic              msb
);
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)        sh <= '1;
        else if (load)  sh <= din;
        else if (shift) sh <= {sh[BYTE_W-2:0], 1'b1};
    end

    assign msb = sh[BYTE_W-1];

    // R6: popped byte leads with its MSB
    a_r6_load_msb_first: assert property (@(posedge clk) disable iff (rst)
        load |=> (msb == $past(din[BYTE_W-1])));
endmodule

// File: rtl/sif_host_slave.sv
module sif_host_slave
    import sif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sif_cs,
    input  logic              sif_sck,
    input  logic              sif_sdi,
    output logic              sif_sdo,
    output logic              sif_sdo_oe,
    output logic              sif_busy_n,
    input  logic [CODE_W-1:0] cfg_mode_code,
    input  logic              cfg_tristate,
    output logic              cmd_wr_valid,
    output logic [BYTE_W-1:0] cmd_wr_data,
    output logic              cmd_end,
    input  logic              cmd_consumed,
    output logic              rsp_rd_req,
    input  logic [BYTE_W-1:0] rsp_rd_data
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;
    logic cs_s, sck_s, sdi_s, sck_rise, sck_fall, sck_r, sck_f;

    sif_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .din({sif_sdi, sif_sck, sif_cs}),
        .dout(sync_q)
    );
    assign cs_s  = sync_q[0];
    assign sck_s = sync_q[1];
    assign sdi_s = sync_q[2];

    sif_edge u_sck_edge (
        .clk(clk), .rst(rst), .lvl(sck_s),
        .rise(sck_rise), .fall(sck_fall)
    );
    assign sck_r = sck_rise & cs_s;
    assign sck_f = sck_fall & cs_s;

    logic [CNT_W-1:0]  rx_cnt;
    logic              rx_stb;
    logic [BYTE_W-1:0] rx_byte;

    sif_rx u_rx (
        .clk(clk), .rst(rst), .clear(~cs_s),
        .bit_stb(sck_r), .bit_in(sdi_s),
        .cnt(rx_cnt), .byte_stb(rx_stb), .byte_q(rx_byte)
    );

    sif_state_e state;
    sif_hdr_t   hdr;
    logic       wrote, tx_on, tx_shift, tx_msb;

    assign hdr        = hdr_decode(rx_byte[BYTE_W-1:1]);
    assign rsp_rd_req = (state == ST_READ) && sck_f && (rx_cnt == '0);
    assign tx_shift   = (state == ST_READ) && sck_f && (rx_cnt != '0);

    sif_tx u_tx (
        .clk(clk), .rst(rst), .load(rsp_rd_req), .shift(tx_shift),
        .din(rsp_rd_data), .msb(tx_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            sif_busy_n   <= 1'b1;
            wrote        <= 1'b0;
            tx_on        <= 1'b0;
            cmd_wr_valid <= 1'b0;
            cmd_wr_data  <= '0;
            cmd_end      <= 1'b0;
        end else begin
            cmd_wr_valid <= 1'b0;
            cmd_end      <= 1'b0;
            if (!sif_busy_n && cmd_consumed) sif_busy_n <= 1'b1;
            if (!cs_s) begin
                if (state == ST_WRITE && wrote) begin
                    sif_busy_n <= 1'b0;
                    cmd_end    <= 1'b1;
                end
                state <= ST_IDLE;
                wrote <= 1'b0;
                tx_on <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: state <= ST_MODE;
                    ST_MODE: if (rx_stb) begin
                        if (hdr.code == cfg_mode_code && sif_busy_n)
                            state <= hdr.rd ? ST_READ : ST_WRITE;
                        else
                            state <= ST_REJECT;
                    end
                    ST_WRITE: if (rx_stb) begin
                        cmd_wr_valid <= 1'b1;
                        cmd_wr_data  <= rx_byte;
                        wrote        <= 1'b1;
                    end
                    ST_READ: if (sck_f) tx_on <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            ST_WRITE: sif_sdo = 1'b0;
            ST_READ:  sif_sdo = tx_on ? tx_msb : 1'b0;
            default:  sif_sdo = 1'b1;
        endcase
    end

    assign sif_sdo_oe = ~cfg_tristate | cs_s;

    // R5: pushes only come out of an accepted write
    a_r5_push_from_write: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_valid |-> ($past(state) == ST_WRITE));

    // R4: a refused header never pushes
    a_r4_reject_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT) |-> !cmd_wr_valid);

    // R8: busy only set by the end of a write
    a_r8_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $fell(sif_busy_n) |-> ($past(state) == ST_WRITE));

    // R8: busy only released by consumption
    a_r8_busy_release: assert property (@(posedge clk) disable iff (rst)
        $rose(sif_busy_n) |-> $past(cmd_consumed));
endmodule

// File: tb/sif_host_slave_tb.sv
module sif_host_slave_tb;
    localparam int HALF = 4;
    localparam int GAP  = 6;
    localparam logic [5:0] MCODE = 6'h2D;

    logic clk = 0, rst = 1;
    logic sif_cs = 0, sif_sck = 1, sif_sdi = 0;
    logic sif_sdo, sif_sdo_oe, sif_busy_n;
    logic cfg_tristate = 0, cmd_consumed = 0;
    logic cmd_wr_valid, cmd_end, rsp_rd_req;
    logic [7:0] cmd_wr_data, rsp_rd_data;

    int n_chk = 0, n_fail = 0;
    int push_cnt = 0, end_cnt = 0, pop_idx = 0;
    logic [7:0] push_log [256];
    logic [7:0] exp_log  [256];
    int exp_push = 0, exp_pop = 0, exp_end = 0;
    bit exp_busy = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sif_host_slave u_dut (
        .clk(clk), .rst(rst), .sif_cs(sif_cs), .sif_sck(sif_sck), .sif_sdi(sif_sdi),
        .sif_sdo(sif_sdo), .sif_sdo_oe(sif_sdo_oe), .sif_busy_n(sif_busy_n),
        .cfg_mode_code(MCODE), .cfg_tristate(cfg_tristate),
        .cmd_wr_valid(cmd_wr_valid), .cmd_wr_data(cmd_wr_data), .cmd_end(cmd_end),
        .cmd_consumed(cmd_consumed), .rsp_rd_req(rsp_rd_req), .rsp_rd_data(rsp_rd_data)
    );

    function automatic logic [7:0] rsp_val(input int i);
        return 8'hA5 ^ 8'(i * 37);
    endfunction

    assign rsp_rd_data = rsp_val(pop_idx);

    always @(posedge clk) if (!rst && rsp_rd_req) pop_idx <= pop_idx + 1;

    always @(negedge clk) begin
        if (!rst && cmd_wr_valid) begin
            push_log[push_cnt[7:0]] = cmd_wr_data;
            push_cnt = push_cnt + 1;
        end
        if (!rst && cmd_end) end_cnt = end_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] tb, input int n, output logic [7:0] rb);
        rb = '1;
        for (int i = 7; i > 7 - n; i--) begin
            sif_sck = 0; sif_sdi = tb[i]; tick(HALF);
            rb[i] = sif_sdo;
            sif_sck = 1; tick(HALF);
        end
    endtask

    task automatic consume();
        cmd_consumed = 1; tick(1); cmd_consumed = 0; tick(2);
        exp_busy = 0;
        chk("R8 busy released by consume", 32'(sif_busy_n), 32'd1);
    endtask

    task automatic run_xfer(input logic [5:0] code, input logic rd, input logic lsb, input int nb);
        logic [7:0] rb, d;
        bit acc;
        acc = (code == MCODE) && !exp_busy;
        sif_cs = 1; tick(GAP);
        bits({code, rd, lsb}, 8, rb);
        tick(GAP);
        chk(acc ? "R3 ack low" : "R4 nack high", 32'(sif_sdo), acc ? 32'd0 : 32'd1);
        for (int b = 0; b < nb; b++) begin
            if (rd) begin
                bits(8'hFF, 8, rb);
                if (acc) begin
                    chk("R6 read byte", 32'(rb), 32'(rsp_val(exp_pop)));
                    exp_pop++;
                end else chk("R4 refused read stays high", 32'(rb), 32'hFF);
            end else begin
                d = 8'($urandom);
                bits(d, 8, rb);
                tick(GAP);
                chk(acc ? "R5 ack held" : "R4 line high", 32'(sif_sdo), acc ? 32'd0 : 32'd1);
                if (acc) begin exp_log[exp_push[7:0]] = d; exp_push++; end
            end
        end
        tick(GAP);
        sif_cs = 0; tick(8);
        if (acc && !rd && nb > 0) begin exp_busy = 1; exp_end++; end
        chk("R5 push count", 32'(push_cnt), 32'(exp_push));
        for (int k = 0; k < push_cnt && k < 256; k++)
            if (push_log[k] !== exp_log[k]) chk("R5 push data", 32'(push_log[k]), 32'(exp_log[k]));
        chk("R6 pop count", 32'(pop_idx), 32'(exp_pop));
        chk("R8 end pulses", 32'(end_cnt), 32'(exp_end));
        chk("R8 R10 busy level", 32'(sif_busy_n), 32'(!exp_busy));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        void'($urandom(32'd4711));
        tick(5); rst = 0; tick(4);
        // R1 reset state
        chk("R1 busy_n", 32'(sif_busy_n), 32'd1);
        chk("R1 sdo", 32'(sif_sdo), 32'd1);
        chk("R1 sdo_oe", 32'(sif_sdo_oe), 32'd1);
        chk("R1 no push", 32'(push_cnt), 32'd0);

        // R2 R3 R5: accepted write, header bit 0 set (ignored)
        run_xfer(MCODE, 1'b0, 1'b1, 2);
        // R8: busy blocks a matching header
        run_xfer(MCODE, 1'b0, 1'b0, 1);
        run_xfer(MCODE, 1'b1, 1'b0, 1);
        consume();
        // R6 R10: read does not set busy
        run_xfer(MCODE, 1'b1, 1'b0, 3);
        // R4 mismatch
        run_xfer(MCODE ^ 6'h01, 1'b0, 1'b0, 2);
        run_xfer(MCODE ^ 6'h20, 1'b1, 1'b0, 1);

        // R7: abort inside a command byte
        sif_cs = 1; tick(GAP);
        bits({MCODE, 1'b0, 1'b0}, 8, rb);
        bits(8'hC3, 4, rb);
        sif_cs = 0; tick(8);
        chk("R7 partial byte not pushed", 32'(push_cnt), 32'(exp_push));
        chk("R7 no busy after empty write", 32'(sif_busy_n), 32'd1);
        // R7: abort inside the header, then a clean write
        sif_cs = 1; tick(GAP);
        bits(8'h5A, 3, rb);
        sif_cs = 0; tick(8);
        run_xfer(MCODE, 1'b0, 1'b0, 1);
        consume();

        // R9 tri-state control
        cfg_tristate = 1; tick(2);
        chk("R9 released while deselected", 32'(sif_sdo_oe), 32'd0);
        sif_cs = 1; tick(GAP);
        chk("R9 driven while selected", 32'(sif_sdo_oe), 32'd1);
        sif_cs = 0; tick(GAP);
        chk("R9 released again", 32'(sif_sdo_oe), 32'd0);
        cfg_tristate = 0; tick(2);
        chk("R9 push-pull always driven", 32'(sif_sdo_oe), 32'd1);

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [5:0] c;
            c = ($urandom % 3 == 0) ? (MCODE ^ 6'(1 + $urandom % 63)) : MCODE;
            run_xfer(c, 1'($urandom), 1'($urandom), 1 + int'($urandom % 3));
            if (exp_busy && ($urandom % 2 == 0)) consume();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule